// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the memory side of an asynchronous DRAM-style strobe interface. It oversamples the four active-low strobes (row strobe, column strobe, write enable and output enable) together with the multiplexed address and the write data on a fast local clock. From the order in which the strobe edges arrive, it works out what kind of memory cycle the host is running. It then hands a single decoded command per access to a behavioural storage model. The storage array is not part of this block.

Row and column addresses are captured on the edges that qualify them. Column-before-row cycles take their row from an internal refresh counter, which then advances. The block also produces the read-data drive enable. It follows extended-data-out rules: read data stays driven after the column strobe rises, and it survives a hidden refresh.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After a synchronous reset, `cmd_valid` and `dq_oe` are low and the refresh row counter is 0.
- R2: While both the row and column strobes are high, no command is issued and `dq_oe` is driven low.
- R3: If the column strobe is already low when the row strobe falls, the block issues opcode 7 (column-before-row refresh), unless R11 applies. The command row is the refresh counter value and the address pins are ignored. `dq_oe` stays low. The counter then increments by one and wraps from 2047 to 0.
- R4: A row-strobe low period during which the column strobe never falls ends, at the row strobe's rise, with opcode 6 (row-only refresh). Its row is the address captured when the row strobe fell.
- R5: With write enable high, a read (opcode 1) is issued at the later of the column-strobe fall and the output-enable fall. Its column is the one captured at the column-strobe fall. `dq_oe` goes high with the command.
- R6: If write enable is already low when the column strobe falls, an early write (opcode 2) is issued with the data present at that sample. `dq_oe` stays low, and later data changes have no effect.
- R7: If write enable falls after the column strobe with no read issued in that column access, a write (opcode 2) is issued with the data present at the write-enable fall.
- R8: If write enable falls after a read in the same column access, a read-write (opcode 3) is issued and `dq_oe` drops.
- R9: Every column-strobe fall after the first one within one row-strobe low period latches a new column and keeps the row. It issues page read (opcode 4) or page write (opcode 5) instead of opcodes 1 or 2.
- R10: `dq_oe`, once set by a read, stays high after the column strobe rises. It is cleared by the next column-strobe fall, an output-enable rise, a write-enable fall, or both strobes high.
- R11: If the row strobe rises and falls again after a read while the column strobe stays low, the block issues opcode 8 (hidden refresh). It uses and advances the refresh counter as in R3, and `dq_oe` stays high.
- R12: Each command is a one-cycle `cmd_valid` pulse with a non-zero opcode. It appears after the second rising clock edge that follows the strobe change reaching the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data from the pins |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Command opcode (1..8) |
| cmd_row | output | ADDR_W | Row of the command |
| cmd_col | output | ADDR_W | Column of the command (0 for refresh) |
| cmd_wdata | output | DATA_W | Write data of the command |
| dq_oe | output | 1 | Read-data drive enable |

## Verification
The cycle decoder is exercised with strobe orderings that differ only in which edge comes last. Column-strobe versus output-enable first tells a pending access from an immediate read. Write enable falling before, with, or after the column strobe separates early write, late write and read-write. Column-strobe-low before row fall separates a plain refresh from a hidden refresh, depending on whether read data is still held. Row-only refresh is checked with the address changing mid-cycle, to show the row is taken at the falling edge. The column-before-row loop runs through the whole counter range, to show the rows are sequential and wrap to zero.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_READ     = 4'd1,
        OP_WRITE    = 4'd2,
        OP_RDWR     = 4'd3,
        OP_PG_READ  = 4'd4,
        OP_PG_WRITE = 4'd5,
        OP_ROW_REF  = 4'd6,
        OP_CBR_REF  = 4'd7,
        OP_HID_REF  = 4'd8
    } cyc_op_e;

    // Strobe levels, 1 = pin high (inactive)
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

    function automatic strobe_t falls(input strobe_t prev, input strobe_t cur);
        return prev & ~cur;
    endfunction

    function automatic cyc_op_e pick(input logic page, input cyc_op_e first, input cyc_op_e later);
        return page ? later : first;
    endfunction

endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync
    import dram_cyc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           pins,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output strobe_t           lvl,
    output strobe_t           fall,
    output logic              ras_rise,
    output logic              oe_rise,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] din_o
);
    strobe_t cur_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '1;
            prev_q <= '1;
            addr_o <= '0;
            din_o  <= '0;
        end else begin
            cur_q  <= pins;
            prev_q <= cur_q;
            addr_o <= addr_i;
            din_o  <= din_i;
        end
    end

    assign lvl      = cur_q;
    assign fall     = falls(prev_q, cur_q);
    assign ras_rise = ~prev_q.ras & cur_q.ras;
    assign oe_rise  = ~prev_q.oe & cur_q.oe;
endmodule

// File: rtl/dram_ref_counter.sv
module dram_ref_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)      row <= '0;
        else if (adv) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_dq_enable.sv
module dram_dq_enable (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic oe_o
);
    always_ff @(posedge clk) begin
        if (rst)        oe_o <= 1'b0;
        else if (set_i) oe_o <= 1'b1;
        else if (clr_i) oe_o <= 1'b0;
    end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dram_cyc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              cmd_valid,
    output logic [3:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_row,
    output logic [ADDR_W-1:0] cmd_col,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              dq_oe
);
    localparam int REF_W = ADDR_W;

    strobe_t           lvl, fl;
    logic              ras_up, oe_up;
    logic [ADDR_W-1:0] a_s;
    logic [DATA_W-1:0] d_s;
    logic [REF_W-1:0]  ref_row;
    logic              dq_q;

    dram_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
        .clk(clk), .rst(rst),
        .pins({ras_n, cas_n, we_n, oe_n}),
        .addr_i(addr), .din_i(din),
        .lvl(lvl), .fall(fl), .ras_rise(ras_up), .oe_rise(oe_up),
        .addr_o(a_s), .din_o(d_s)
    );

    // Access state within one row-strobe low period
    logic [ADDR_W-1:0] row_q, row_n, col_q, col_n;
    logic open_q, open_n, seen_q, seen_n, pend_q, pend_n;
    logic rdone_q, rdone_n, pg_q, pg_n;

    logic              iss, ref_adv, oe_set, oe_clr;
    cyc_op_e           iop, op_q;
    logic [ADDR_W-1:0] irow, icol;

    dram_ref_counter #(.W(REF_W)) u_ref (
        .clk(clk), .rst(rst), .adv(ref_adv), .row(ref_row)
    );

    dram_dq_enable u_dq (
        .clk(clk), .rst(rst), .set_i(oe_set), .clr_i(oe_clr), .oe_o(dq_q)
    );

    always_comb begin
        row_n   = row_q;   col_n  = col_q;  open_n = open_q; seen_n = seen_q;
        pend_n  = pend_q;  rdone_n = rdone_q; pg_n  = pg_q;
        iss     = 1'b0;    iop    = OP_NONE;
        irow    = row_q;   icol   = col_q;
        ref_adv = 1'b0;    oe_set = 1'b0;
        oe_clr  = fl.cas | fl.we | oe_up | (lvl.ras & lvl.cas);
        if (fl.ras) begin
            if (!lvl.cas) begin
                iss     = 1'b1;
                iop     = dq_q ? OP_HID_REF : OP_CBR_REF;
                irow    = ref_row;
                icol    = '0;
                ref_adv = 1'b1;
                open_n  = 1'b0;
            end else begin
                row_n  = a_s;
                open_n = 1'b1;
                seen_n = 1'b0;
                pend_n = 1'b0;
                rdone_n = 1'b0;
            end
        end else if (ras_up) begin
            if (open_q && !seen_q) begin
                iss  = 1'b1;
                iop  = OP_ROW_REF;
                icol = '0;
            end
            open_n  = 1'b0;
            pend_n  = 1'b0;
            rdone_n = 1'b0;
        end else if (open_q) begin
            if (fl.cas) begin
                col_n   = a_s;
                icol    = a_s;
                seen_n  = 1'b1;
                pg_n    = seen_q;
                rdone_n = 1'b0;
                pend_n  = 1'b0;
                if (!lvl.we) begin
                    iss = 1'b1;
                    iop = pick(seen_q, OP_WRITE, OP_PG_WRITE);
                end else if (!lvl.oe) begin
                    iss     = 1'b1;
                    iop     = pick(seen_q, OP_READ, OP_PG_READ);
                    oe_set  = 1'b1;
                    rdone_n = 1'b1;
                end else begin
                    pend_n = 1'b1;
                end
            end else if (!lvl.cas) begin
                if (fl.we) begin
                    if (rdone_q) begin
                        iss     = 1'b1;
                        iop     = OP_RDWR;
                        rdone_n = 1'b0;
                    end else if (pend_q) begin
                        iss    = 1'b1;
                        iop    = pick(pg_q, OP_WRITE, OP_PG_WRITE);
                        pend_n = 1'b0;
                    end
                end else if (fl.oe && lvl.we && pend_q) begin
                    iss     = 1'b1;
                    iop     = pick(pg_q, OP_READ, OP_PG_READ);
                    oe_set  = 1'b1;
                    rdone_n = 1'b1;
                    pend_n  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0; col_q <= '0; open_q <= 1'b0; seen_q <= 1'b0;
            pend_q <= 1'b0; rdone_q <= 1'b0; pg_q <= 1'b0;
            cmd_valid <= 1'b0; op_q <= OP_NONE;
            cmd_row <= '0; cmd_col <= '0; cmd_wdata <= '0;
        end else begin
            row_q <= row_n; col_q <= col_n; open_q <= open_n; seen_q <= seen_n;
            pend_q <= pend_n; rdone_q <= rdone_n; pg_q <= pg_n;
            cmd_valid <= iss;
            if (iss) begin
                op_q      <= iop;
                cmd_row   <= irow;
                cmd_col   <= icol;
                cmd_wdata <= d_s;
            end
        end
    end

    assign cmd_op = op_q;
    assign dq_oe  = dq_q;

    // R2
    standby_off_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl.ras && lvl.cas) |=> !dq_oe);
    // R3
    cbr_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (fl.ras && !lvl.cas) |=> (cmd_valid && (cmd_op == OP_CBR_REF || cmd_op == OP_HID_REF)));
    // R3
    cbr_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_CBR_REF) |-> !dq_oe);
    // R5
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_READ || cmd_op == OP_PG_READ)) |-> dq_oe);
    // R6
    write_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_WRITE || cmd_op == OP_PG_WRITE)) |-> !dq_oe);
    // R8
    rdwr_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RDWR) |-> !dq_oe);
    // R11
    hidden_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_HID_REF) |-> dq_oe);
    // R12
    op_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op != OP_NONE));
endmodule

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NV = 31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic cmd_valid, dq_oe;
    logic [3:0] cmd_op;
    logic [AW-1:0] cmd_row, cmd_col;
    logic [DW-1:0] cmd_wdata;

    always #4 clk = ~clk;

    dram_cycle_decoder #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .dq_oe(dq_oe)
    );

    // {ras,cas,we,oe, addr, din, exp_valid, exp_op, exp_dq_oe, pad}
    localparam logic [31:0] VEC [NV] = '{
        {4'b1111, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  //  0 R2 standby
        {4'b0111, 11'h123, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  //  1 row open
        {4'b0011, 11'h045, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  //  2 R5 CAS first, pending
        {4'b0010, 11'h000, 8'h00, 1'b1, 4'd1, 1'b1, 3'd0},  //  3 R5 OE last -> read
        {4'b0110, 11'h000, 8'h00, 1'b0, 4'd0, 1'b1, 3'd0},  //  4 R10 CAS up, data held
        {4'b0010, 11'h046, 8'h00, 1'b1, 4'd4, 1'b1, 3'd0},  //  5 R9 page read
        {4'b0000, 11'h000, 8'h3C, 1'b1, 4'd3, 1'b0, 3'd0},  //  6 R8 read-write
        {4'b0110, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  //  7 R9 CAS up
        {4'b0101, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  //  8 R9 WE first
        {4'b0001, 11'h047, 8'h77, 1'b1, 4'd5, 1'b0, 3'd0},  //  9 R9 page write
        {4'b1111, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 10 R2 standby
        {4'b0111, 11'h200, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 11 R4 row only
        {4'b1111, 11'h000, 8'h00, 1'b1, 4'd6, 1'b0, 3'd0},  // 12 R4 row-only refresh
        {4'b1011, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 13 R3 CAS first
        {4'b0011, 11'h555, 8'h00, 1'b1, 4'd7, 1'b0, 3'd0},  // 14 R3 CBR refresh
        {4'b1011, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 15 R3 RAS up
        {4'b1111, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 16 R2 standby
        {4'b0111, 11'h010, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 17 R6 row open
        {4'b0001, 11'h020, 8'h99, 1'b1, 4'd2, 1'b0, 3'd0},  // 18 R6 early write
        {4'b1111, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 19 R2 standby
        {4'b0111, 11'h011, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 20 R7 row open
        {4'b0011, 11'h021, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 21 R7 CAS, WE high
        {4'b0001, 11'h000, 8'h42, 1'b1, 4'd2, 1'b0, 3'd0},  // 22 R7 late write
        {4'b1111, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 23 R2 standby
        {4'b0111, 11'h012, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 24 R11 row open
        {4'b0010, 11'h022, 8'h00, 1'b1, 4'd1, 1'b1, 3'd0},  // 25 R5 read
        {4'b1010, 11'h000, 8'h00, 1'b0, 4'd0, 1'b1, 3'd0},  // 26 R11 RAS up, CAS low
        {4'b0010, 11'h000, 8'h00, 1'b1, 4'd8, 1'b1, 3'd0},  // 27 R11 hidden refresh
        {4'b1010, 11'h000, 8'h00, 1'b0, 4'd0, 1'b1, 3'd0},  // 28 R11 data still held
        {4'b1110, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0},  // 29 R2 both high
        {4'b1111, 11'h000, 8'h00, 1'b0, 4'd0, 1'b0, 3'd0}   // 30 R2 standby
    };

    string TAG [NV] = '{"R2","R4","R5","R5","R10","R9","R8","R9","R9","R9","R2",
                        "R4","R4","R3","R3","R3","R2","R6","R6","R2","R7","R7",
                        "R7","R2","R11","R5","R11","R11","R11","R2","R2"};

    int n_chk = 0, n_fail = 0, n_cmd = 0;
    logic [3:0] last_op = '0;
    logic [AW-1:0] last_row = '0, last_col = '0;
    logic [DW-1:0] last_wd = '0;
    logic prev_v = 1'b0, pulse_err = 1'b0;
    logic [31:0] e;
    int n0, bad_rows;

    always @(negedge clk) begin
        if (cmd_valid) begin
            n_cmd++;
            last_op = cmd_op; last_row = cmd_row; last_col = cmd_col; last_wd = cmd_wdata;
            if (prev_v) pulse_err = 1'b1;
        end
        prev_v = cmd_valid;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic c, input logic w, input logic o,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic cbr(input logic [AW-1:0] a);
        drive(1, 0, 1, 1, a, 0);
        drive(0, 0, 1, 1, a, 0);
        drive(1, 0, 1, 1, a, 0);
        drive(1, 1, 1, 1, a, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
        check(dq_oe == 1'b0, "R1", "dq_oe after reset", dq_oe, 0);

        for (int i = 0; i < NV; i++) begin
            e  = VEC[i];
            n0 = n_cmd;
            drive(e[31], e[30], e[29], e[28], e[27:17], e[16:9]);
            check((n_cmd - n0) == int'(e[8]), TAG[i], $sformatf("step %0d command count", i), n_cmd - n0, e[8]);
            if (e[8])
                check(last_op == e[7:4], TAG[i], $sformatf("step %0d opcode", i), last_op, e[7:4]);
            check(dq_oe == e[3], TAG[i], $sformatf("step %0d dq_oe", i), dq_oe, e[3]);
        end

        // R8 read-write data came from the write-enable fall
        drive(0, 1, 1, 1, 11'h0AA, 0);
        drive(0, 0, 1, 0, 11'h0BB, 0);
        drive(0, 0, 0, 0, 0, 8'hD2);
        check(last_op == 4'd3 && last_wd == 8'hD2, "R8", "read-write data", last_wd, 8'hD2);
        drive(1, 1, 1, 1, 0, 0);

        // R5 column captured at CAS fall, not at OE fall
        drive(0, 1, 1, 1, 11'h3A5, 0);
        n0 = n_cmd;
        drive(0, 0, 1, 1, 11'h0F0, 0);
        check(n_cmd == n0 && dq_oe == 1'b0, "R5", "no read before OE", n_cmd - n0, 0);
        drive(0, 0, 1, 0, 11'h000, 0);
        check(last_op == 4'd1, "R5", "read opcode", last_op, 1);
        check(last_row == 11'h3A5, "R5", "read row", last_row, 11'h3A5);
        check(last_col == 11'h0F0, "R5", "read column", last_col, 11'h0F0);
        // R10 held after CAS rise, cleared by OE rise
        drive(0, 1, 1, 0, 0, 0);
        check(dq_oe == 1'b1, "R10", "held after CAS rise", dq_oe, 1);
        drive(0, 1, 1, 1, 0, 0);
        check(dq_oe == 1'b0, "R10", "cleared by OE rise", dq_oe, 0);
        // R9 new column, same row
        drive(0, 0, 1, 0, 11'h011, 0);
        check(last_op == 4'd4 && last_row == 11'h3A5 && last_col == 11'h011,
              "R9", "page read row/col", last_col, 11'h011);
        drive(1, 1, 1, 1, 0, 0);

        // R6 early write data captured at CAS fall, later changes ignored
        drive(0, 1, 0, 1, 11'h001, 0);
        drive(0, 0, 0, 1, 11'h002, 8'hA5);
        n0 = n_cmd;
        drive(0, 0, 0, 1, 11'h002, 8'h5A);
        check(last_op == 4'd2 && last_wd == 8'hA5, "R6", "early write data", last_wd, 8'hA5);
        check(n_cmd == n0 && dq_oe == 1'b0, "R6", "no further command, output off", n_cmd - n0, 0);
        drive(1, 1, 1, 1, 0, 0);

        // R4 row taken at RAS fall even if address then changes
        drive(0, 1, 1, 1, 11'h155, 0);
        drive(0, 1, 1, 1, 11'h2AA, 0);
        drive(1, 1, 1, 1, 0, 0);
        check(last_op == 4'd6 && last_row == 11'h155, "R4", "row-only refresh row", last_row, 11'h155);

        // R3 counter row (two refreshes so far in table), pins ignored
        cbr(11'h7FF);
        check(last_op == 4'd7 && last_row == 11'd2, "R3", "refresh row from counter", last_row, 2);
        bad_rows = 0;
        for (int k = 3; k <= 2048; k++) begin
            cbr(11'h7FF);
            if (last_row != k[AW-1:0] || last_op != 4'd7) bad_rows++;
        end
        check(bad_rows == 0, "R3", "sequential refresh rows", bad_rows, 0);
        check(last_row == 11'd0, "R3", "counter wrap to 0", last_row, 0);
        check(dq_oe == 1'b0, "R3", "outputs off after refresh", dq_oe, 0);

        // R12 single-cycle pulses throughout
        check(pulse_err == 1'b0, "R12", "one-cycle command pulse", pulse_err, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule